// File: doc/BRIEF.md
# Byte and Word Load/Store Lane Unit

This block connects the execute stage of a processor core to a data memory that is addressed per byte but stored as 32-bit words. Each cycle it may accept one request. A request carries an effective byte address, a store value and two flags: one selects load or store, the other selects word or byte size. For a store, the block drives the word address, a per-byte write-enable mask and write data that is already placed in the right lanes. For a load, it sends the read to the memory. In the following cycle it takes the returned word and, for a byte load, picks out the addressed byte and sign-extends it.

A word occupies four consecutive byte addresses. A word access is legal only on a multiple of four. Any other word access raises an error flag in the request cycle and never reaches the memory. Array element i of a word array sits at base + 4*i, so every such aligned address is accepted. Byte order inside a word is big-endian: the byte at offset 0 is carried in bits [31:24]. Lane width, word width and byte order are parameters. The defaults give a 32-bit word with big-endian lanes.

Top module: `lsu_bw`

## Requirements
- R1: For every accepted request, `mem_word_addr` equals `req_addr` shifted right by 2, and `mem_en` is high in the same cycle.
- R2: A word-size request whose `req_addr[1:0]` is not 0 raises `misalign` in the same cycle. For that request `mem_en` and `mem_we` stay low and `mem_be` is 0, so the memory contents do not change.
- R3: A word store drives `mem_we` high, `mem_be` = 4'b1111 and `mem_wdata` equal to `req_wdata`.
- R4: A byte store drives a one-hot `mem_be`, where bit k enables `mem_wdata[8k+7:8k]`. Offset 0 gives 4'b1000, offset 1 gives 4'b0100, offset 2 gives 4'b0010 and offset 3 gives 4'b0001. Every lane of `mem_wdata` carries `req_wdata[7:0]`, so bits [31:8] of the store value never reach memory.
- R5: One cycle after a byte load, `ld_data[7:0]` holds the addressed byte (offset 0 is `mem_rdata[31:24]`, offset 3 is `mem_rdata[7:0]`), and bits [31:8] are copies of its bit 7.
- R6: One cycle after an aligned word load, `ld_valid` is high and `ld_data` equals the whole returned word.
- R7: `ld_valid` is high only in the cycle that follows an accepted load. It stays low after stores, idle cycles and misaligned loads.
- R8: While reset is asserted and in any cycle with `req_valid` low, `ld_valid`, `mem_en`, `mem_we` and `misalign` are low and `mem_be` is 0.
- R9: A byte request at any offset never raises `misalign`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | A request is present this cycle |
| req_store | input | 1 | 1 = store, 0 = load |
| req_byte | input | 1 | 1 = byte access, 0 = word access |
| req_addr | input | 32 | Effective byte address |
| req_wdata | input | 32 | Store source value |
| mem_en | output | 1 | Memory access enable |
| mem_we | output | 1 | Memory write enable |
| mem_word_addr | output | 30 | Word index into the memory |
| mem_be | output | 4 | Byte enables, bit k covers data bits [8k+7:8k] |
| mem_wdata | output | 32 | Lane-placed write data |
| mem_rdata | input | 32 | Word read back one cycle after `mem_en` |
| ld_valid | output | 1 | Load result present |
| ld_data | output | 32 | Aligned, extended load result |
| misalign | output | 1 | Illegal word alignment on the current request |

## Verification
The assertions assume that the request fields carry known values whenever `req_valid` is high. They also assume that the memory returns a word exactly one cycle after an enabled read. The load checks only relate the response cycle to the request captured at the previous edge. The bench drives every request at the falling edge, so the fields are settled well before the next rising edge. Its memory model registers its read data on the same rising edge that the block uses to capture its load state. Addresses stay inside the model's sixteen words, so every read returns data that the bench itself wrote.

// File: rtl/lsu_pkg.sv
package lsu_pkg;
   // access size as carried by req_byte
   typedef enum logic {
      SZ_WORD = 1'b0,
      SZ_BYTE = 1'b1
   } acc_size_e;
endpackage

// File: rtl/lsu_lane_sel.sv
// Maps a byte offset inside a word to the lane index counted from the least significant bits.
module lsu_lane_sel #(
   parameter int LANES      = 4,
   parameter int OFS_W      = 2,
   parameter bit BIG_ENDIAN = 1'b1
) (
   input  logic [OFS_W-1:0] ofs,
   output logic [OFS_W-1:0] lane
);
   localparam logic [OFS_W-1:0] TOP_LANE = OFS_W'(LANES - 1);

   generate
      if (BIG_ENDIAN) begin : g_big
         assign lane = TOP_LANE - ofs;
      end else begin : g_little
         assign lane = ofs;
      end
   endgenerate
endmodule

// File: rtl/lsu_align_chk.sv
module lsu_align_chk #(
   parameter int OFS_W = 2
) (
   input  logic             req_valid,
   input  logic             is_byte,
   input  logic [OFS_W-1:0] ofs,
   output logic             misalign
);
   assign misalign = req_valid && !is_byte && (ofs != '0);
endmodule

// File: rtl/lsu_store_fmt.sv
module lsu_store_fmt #(
   parameter int DATA_W = 32,
   parameter int LANES  = DATA_W / 8,
   parameter int OFS_W  = $clog2(LANES)
) (
   input  logic              is_byte,
   input  logic [OFS_W-1:0]  lane,
   input  logic [DATA_W-1:0] src,
   output logic [LANES-1:0]  be,
   output logic [DATA_W-1:0] wdata
);
   always_comb begin
      be = '0;
      if (is_byte) be[lane] = 1'b1;
      else         be = '1;
   end

   generate
      for (genvar k = 0; k < LANES; k++) begin : g_lane
         assign wdata[k*8 +: 8] = is_byte ? src[7:0] : src[k*8 +: 8];
      end
   endgenerate
endmodule

// File: rtl/lsu_load_ext.sv
module lsu_load_ext #(
   parameter int DATA_W = 32,
   parameter int LANES  = DATA_W / 8,
   parameter int OFS_W  = $clog2(LANES)
) (
   input  logic              is_byte,
   input  logic [OFS_W-1:0]  lane,
   input  logic [DATA_W-1:0] rdata,
   output logic [DATA_W-1:0] data
);
   logic [7:0] picked;

   always_comb begin
      picked = '0;
      for (int k = 0; k < LANES; k++) begin
         if (lane == OFS_W'(k)) picked = rdata[k*8 +: 8];
      end
   end

   assign data = is_byte ? {{(DATA_W-8){picked[7]}}, picked} : rdata;
endmodule

// File: rtl/lsu_bw.sv
module lsu_bw #(
   parameter int DATA_W     = 32,
   parameter int ADDR_W     = 32,
   parameter bit BIG_ENDIAN = 1'b1
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          req_valid,
   input  logic                          req_store,
   input  logic                          req_byte,
   input  logic [ADDR_W-1:0]             req_addr,
   input  logic [DATA_W-1:0]             req_wdata,
   output logic                          mem_en,
   output logic                          mem_we,
   output logic [ADDR_W-$clog2(DATA_W/8)-1:0] mem_word_addr,
   output logic [DATA_W/8-1:0]           mem_be,
   output logic [DATA_W-1:0]             mem_wdata,
   input  logic [DATA_W-1:0]             mem_rdata,
   output logic                          ld_valid,
   output logic [DATA_W-1:0]             ld_data,
   output logic                          misalign
);
   import lsu_pkg::*;

   localparam int LANES = DATA_W / 8;
   localparam int OFS_W = $clog2(LANES);

   // elaboration-time parameter checks
   generate
      if (DATA_W % 8 != 0) begin : g_bad_width
         $error("lsu_bw: DATA_W must be a whole number of bytes");
      end
      if (LANES < 2 || (1 << OFS_W) != LANES) begin : g_bad_lanes
         $error("lsu_bw: lane count must be a power of two of at least 2");
      end
      if (ADDR_W <= OFS_W) begin : g_bad_addr
         $error("lsu_bw: ADDR_W too narrow for the lane count");
      end
   endgenerate

   acc_size_e         req_size;
   logic [OFS_W-1:0]  req_lane;
   logic [LANES-1:0]  fmt_be;
   logic [DATA_W-1:0] fmt_wdata;
   logic              ld_pend_q;
   acc_size_e         ld_size_q;
   logic [OFS_W-1:0]  ld_lane_q;

   assign req_size = req_byte ? SZ_BYTE : SZ_WORD;

   lsu_lane_sel #(.LANES(LANES), .OFS_W(OFS_W), .BIG_ENDIAN(BIG_ENDIAN)) u_lane (
      .ofs  (req_addr[OFS_W-1:0]),
      .lane (req_lane)
   );

   lsu_align_chk #(.OFS_W(OFS_W)) u_align (
      .req_valid (req_valid),
      .is_byte   (req_size == SZ_BYTE),
      .ofs       (req_addr[OFS_W-1:0]),
      .misalign  (misalign)
   );

   lsu_store_fmt #(.DATA_W(DATA_W), .LANES(LANES), .OFS_W(OFS_W)) u_st (
      .is_byte (req_size == SZ_BYTE),
      .lane    (req_lane),
      .src     (req_wdata),
      .be      (fmt_be),
      .wdata   (fmt_wdata)
   );

   assign mem_en        = req_valid && !misalign;
   assign mem_we        = mem_en && req_store;
   assign mem_be        = mem_we ? fmt_be : '0;
   assign mem_wdata     = fmt_wdata;
   assign mem_word_addr = req_addr[ADDR_W-1:OFS_W];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ld_pend_q <= 1'b0;
         ld_size_q <= SZ_WORD;
         ld_lane_q <= '0;
      end else begin
         ld_pend_q <= mem_en && !req_store;
         if (mem_en && !req_store) begin
            ld_size_q <= req_size;
            ld_lane_q <= req_lane;
         end
      end
   end

   lsu_load_ext #(.DATA_W(DATA_W), .LANES(LANES), .OFS_W(OFS_W)) u_ld (
      .is_byte (ld_size_q == SZ_BYTE),
      .lane    (ld_lane_q),
      .rdata   (mem_rdata),
      .data    (ld_data)
   );

   assign ld_valid = ld_pend_q;
endmodule

// File: rtl/lsu_bw_chk.sv
module lsu_bw_chk #(
   parameter int DATA_W = 32,
   parameter int ADDR_W = 32
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 req_valid,
   input logic                 req_store,
   input logic                 req_byte,
   input logic                 mem_en,
   input logic                 mem_we,
   input logic [DATA_W/8-1:0]  mem_be,
   input logic                 ld_valid,
   input logic [DATA_W-1:0]    ld_data,
   input logic                 misalign
);
   // R2
   property misalign_blocks_wr_p;
      @(posedge clk) disable iff (!rst_n) misalign |-> (!mem_en && !mem_we && mem_be == '0);
   endproperty
   misalign_blocks_wr_chk: assert property (misalign_blocks_wr_p);

   // R3
   property word_store_full_p;
      @(posedge clk) disable iff (!rst_n)
         (req_valid && req_store && !req_byte && !misalign) |-> (mem_we && mem_be == '1);
   endproperty
   word_store_full_chk: assert property (word_store_full_p);

   // R4
   property byte_store_onehot_p;
      @(posedge clk) disable iff (!rst_n)
         (req_valid && req_store && req_byte) |-> ($countones(mem_be) == 1 && mem_we);
   endproperty
   byte_store_onehot_chk: assert property (byte_store_onehot_p);

   // R5
   property byte_load_sext_p;
      @(posedge clk) disable iff (!rst_n)
         (ld_valid && $past(req_byte)) |-> (ld_data[DATA_W-1:8] == {(DATA_W-8){ld_data[7]}});
   endproperty
   byte_load_sext_chk: assert property (byte_load_sext_p);

   // R7
   property ld_valid_follows_p;
      @(posedge clk) disable iff (!rst_n)
         ld_valid |-> $past(req_valid && !req_store && mem_en);
   endproperty
   ld_valid_follows_chk: assert property (ld_valid_follows_p);

   // R8
   property idle_quiet_p;
      @(posedge clk) disable iff (!rst_n)
         !req_valid |-> (!mem_en && !mem_we && !misalign && mem_be == '0);
   endproperty
   idle_quiet_chk: assert property (idle_quiet_p);

   // R9
   property byte_never_misaligned_p;
      @(posedge clk) disable iff (!rst_n) (req_valid && req_byte) |-> !misalign;
   endproperty
   byte_never_misaligned_chk: assert property (byte_never_misaligned_p);
endmodule

bind lsu_bw lsu_bw_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_valid (req_valid),
   .req_store (req_store),
   .req_byte  (req_byte),
   .mem_en    (mem_en),
   .mem_we    (mem_we),
   .mem_be    (mem_be),
   .ld_valid  (ld_valid),
   .ld_data   (ld_data),
   .misalign  (misalign)
);

// File: tb/sim_lsu_bw.sv
`timescale 1ns/1ps
module sim_lsu_bw;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_store = 1'b0;
   logic        req_byte = 1'b0;
   logic [31:0] req_addr = '0;
   logic [31:0] req_wdata = '0;
   logic        mem_en, mem_we;
   logic [29:0] mem_word_addr;
   logic [3:0]  mem_be;
   logic [31:0] mem_wdata;
   logic [31:0] mem_rdata;
   logic        ld_valid;
   logic [31:0] ld_data;
   logic        misalign;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   lsu_bw u0 (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_store(req_store),
      .req_byte(req_byte), .req_addr(req_addr), .req_wdata(req_wdata),
      .mem_en(mem_en), .mem_we(mem_we), .mem_word_addr(mem_word_addr),
      .mem_be(mem_be), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
      .ld_valid(ld_valid), .ld_data(ld_data), .misalign(misalign)
   );

   // synchronous word memory model, be[k] covers bits [8k+7:8k]
   logic [31:0] mem [16];
   initial for (int i = 0; i < 16; i++) mem[i] = '0;
   always @(posedge clk) begin
      if (mem_en) begin
         mem_rdata <= mem[mem_word_addr[3:0]];
         if (mem_we) begin
            for (int k = 0; k < 4; k++)
               if (mem_be[k]) mem[mem_word_addr[3:0]][k*8 +: 8] <= mem_wdata[k*8 +: 8];
         end
      end
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic issue(input bit st, input bit by, input logic [31:0] a, input logic [31:0] d);
      @(negedge clk);
      req_valid = 1'b1; req_store = st; req_byte = by; req_addr = a; req_wdata = d;
      #1;
   endtask

   task automatic idle();
      @(negedge clk);
      req_valid = 1'b0; req_store = 1'b0; req_byte = 1'b0;
      #1;
   endtask

   // {store, byte, addr[7:0], data[31:0], expected[31:0]}; for stores expected holds mem_be
   localparam logic [73:0] VEC [14] = '{
      {1'b1, 1'b0, 8'h00, 32'h8412_7F01, 32'h0000_000F},
      {1'b1, 1'b0, 8'h04, 32'h1122_3344, 32'h0000_000F},
      {1'b0, 1'b0, 8'h00, 32'h0000_0000, 32'h8412_7F01},
      {1'b0, 1'b1, 8'h00, 32'h0000_0000, 32'hFFFF_FF84},
      {1'b0, 1'b1, 8'h01, 32'h0000_0000, 32'h0000_0012},
      {1'b0, 1'b1, 8'h02, 32'h0000_0000, 32'h0000_007F},
      {1'b0, 1'b1, 8'h03, 32'h0000_0000, 32'h0000_0001},
      {1'b1, 1'b1, 8'h05, 32'hABCD_EF9A, 32'h0000_0004},
      {1'b0, 1'b0, 8'h04, 32'h0000_0000, 32'h119A_3344},
      {1'b1, 1'b1, 8'h07, 32'h0000_00C3, 32'h0000_0001},
      {1'b0, 1'b1, 8'h07, 32'h0000_0000, 32'hFFFF_FFC3},
      {1'b0, 1'b0, 8'h04, 32'h0000_0000, 32'h119A_33C3},
      {1'b1, 1'b1, 8'h00, 32'h0000_0055, 32'h0000_0008},
      {1'b0, 1'b0, 8'h00, 32'h0000_0000, 32'h5512_7F01}
   };

   task automatic finish_run();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   endtask

   initial begin
      #(200000 * 5);
      if (!done) begin
         failures++;
         checks++;
         $display("FAIL watchdog expired actual=%h expected=%h", 32'h0, 32'h1);
         finish_run();
      end
   end

   initial begin
      // R8 reset state
      repeat (3) @(negedge clk);
      chk("R8 ld_valid in reset", {31'b0, ld_valid}, 32'h0);
      chk("R8 mem_en in reset", {31'b0, mem_en}, 32'h0);
      rst_n = 1'b1;
      idle();
      chk("R8 idle mem_be", {28'b0, mem_be}, 32'h0);
      chk("R8 idle misalign", {31'b0, misalign}, 32'h0);

      for (int i = 0; i < 14; i++) begin
         logic [73:0] v;
         logic [31:0] a;
         v = VEC[i];
         a = {24'h0, v[71:64]};
         issue(v[73], v[72], a, v[63:32]);
         chk("R1 word address", {2'b0, mem_word_addr}, a >> 2);
         chk("R1 enable", {31'b0, mem_en}, 32'h1);
         chk("R9 no misalign on legal access", {31'b0, misalign}, 32'h0);
         if (v[73]) begin
            if (v[72]) begin
               chk("R4 byte enables", {28'b0, mem_be}, v[31:0]);
               chk("R4 replicated byte", mem_wdata, {4{v[39:32]}});
            end else begin
               chk("R3 word enables", {28'b0, mem_be}, v[31:0]);
               chk("R3 word data", mem_wdata, v[63:32]);
            end
         end
         idle();
         if (v[73]) begin
            chk("R7 no ld_valid after store", {31'b0, ld_valid}, 32'h0);
         end else begin
            chk("R7 ld_valid after load", {31'b0, ld_valid}, 32'h1);
            chk(v[72] ? "R5 byte load" : "R6 word load", ld_data, v[31:0]);
         end
      end

      // R2 misaligned word store is blocked
      issue(1'b1, 1'b0, 32'h0000_0006, 32'hDEAD_BEEF);
      chk("R2 misalign flag", {31'b0, misalign}, 32'h1);
      chk("R2 write suppressed", {30'b0, mem_en, mem_we}, 32'h0);
      chk("R2 enables zero", {28'b0, mem_be}, 32'h0);
      idle();
      issue(1'b0, 1'b0, 32'h0000_0004, 32'h0);
      idle();
      chk("R2 memory unchanged", ld_data, 32'h119A_33C3);

      // R2 and R7 misaligned word load gives no result
      issue(1'b0, 1'b0, 32'h0000_0002, 32'h0);
      chk("R2 misaligned load flag", {31'b0, misalign}, 32'h1);
      chk("R2 misaligned load enable", {31'b0, mem_en}, 32'h0);
      idle();
      chk("R7 no ld_valid after misaligned load", {31'b0, ld_valid}, 32'h0);

      // R9 odd byte address
      issue(1'b0, 1'b1, 32'h0000_0005, 32'h0);
      chk("R9 odd byte address", {31'b0, misalign}, 32'h0);
      idle();
      chk("R5 byte load offset 1", ld_data, 32'hFFFF_FF9A);
      idle();
      chk("R7 ld_valid drops when idle", {31'b0, ld_valid}, 32'h0);

      done = 1'b1;
      finish_run();
   end
endmodule